// File: doc/BRIEF.md
# Read burst bus and termination sequencer

This block runs the data-bus side of a double-rate graphics memory device while it returns read bursts. Each accepted READ command schedules a four-beat burst. The burst occupies two clock cycles at two beats per cycle, and its first pair of beats starts CL cycles after the command. Around every burst the block turns the on-die termination off and enables the output driver. It holds the bus high for one cycle before the data and one cycle after it. When bursts follow one another closely, the driven window is merged so that the termination does not toggle between them.

The block also watches command spacing. A READ that comes less than two cycles after the previous accepted column command is dropped and raises a sticky flag. A WRITE that comes before the read-to-write delay has elapsed raises a second sticky flag. That delay is CL + 4 − WL cycles, with a floor of zero, computed from the latencies in force for the last accepted READ. CL and WL are taken from the configuration inputs only while the sequencer is idle.

The bus phase is an enumerated state machine with six states:
- PH_IDLE: termination on, driver off.
- PH_PRE: preamble, bus driven high.
- PH_BEAT_A: beats 0 and 1.
- PH_BEAT_B: beats 2 and 3.
- PH_BRIDGE: a single high cycle between two bursts.
- PH_POST: postamble, bus driven high.

The transitions are:
- PH_IDLE→PH_PRE when a burst starts in two cycles.
- PH_PRE→PH_BEAT_A.
- PH_BEAT_A→PH_BEAT_B.
- PH_BEAT_B→PH_BEAT_A when a burst starts in the next cycle (gapless).
- PH_BEAT_B→PH_BRIDGE when a burst starts in two cycles.
- PH_BEAT_B→PH_POST otherwise.
- PH_BRIDGE→PH_BEAT_A.
- PH_POST→PH_PRE when a burst starts in two cycles.
- PH_POST→PH_IDLE otherwise.

Top module: `rd_bus_seq`

## Requirements
- R1: While reset is asserted and after it is released with no command, odt_en=1, drv_en=0, drive_high=0, dq_valid=0, rd_gap_err=0 and wr_gap_err=0.
- R2: A READ accepted in cycle t (cmd_valid=1, cmd_wr=0) gives dq_valid=1 in cycles t+CL and t+CL+1, with dq_pair=0 (beats 0,1) in the first and dq_pair=1 (beats 2,3) in the second; CL is in 3..MAX_CL.
- R3: In cycle t+CL−1 of a lone burst, odt_en=0, drv_en=1, drive_high=1 and dq_valid=0.
- R4: In the cycle after the last data cycle, when no burst follows within two cycles, drive_high=1, drv_en=1 and odt_en=0. In the next cycle odt_en=1 and drv_en=0.
- R5: READs accepted exactly two cycles apart give continuous dq_valid with drive_high=0 and odt_en=0 between the bursts.
- R6: With a spacing of three cycles there is exactly one drive_high cycle between bursts. With a spacing of four, a postamble is followed directly by a preamble, and odt_en stays 0. With a spacing of five, odt_en=1 for exactly one cycle between the postamble and the next preamble.
- R7: A READ arriving one cycle after an accepted READ or after any WRITE (cmd_wr=1) starts no burst. It sets rd_gap_err from the next cycle until reset.
- R8: A WRITE arriving fewer than max(CL+4−WL, 0) cycles after the last accepted READ sets wr_gap_err from the next cycle until reset. A WRITE arriving exactly at that delay does not set it.
- R9: cfg_cl and cfg_wl are used only when the sequencer is idle (no burst pending and phase PH_IDLE). A READ accepted while a burst is in progress uses the latencies of the burst already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Column command present this cycle |
| cmd_wr | input | 1 | 1 = WRITE, 0 = READ |
| cfg_cl | input | LAT_W | CAS latency in cycles (3..MAX_CL) |
| cfg_wl | input | LAT_W | Write latency in cycles |
| odt_en | output | 1 | On-die termination enable |
| drv_en | output | 1 | Output driver enable |
| drive_high | output | 1 | Bus driven high (preamble, bridge, postamble) |
| dq_valid | output | 1 | Both edges of this cycle carry read data |
| dq_pair | output | 1 | 0 = beats 0,1; 1 = beats 2,3 |
| rd_gap_err | output | 1 | Sticky READ spacing violation |
| wr_gap_err | output | 1 | Sticky READ-to-WRITE spacing violation |

## Verification
On every cycle, the assertions check the following:
- A driven window opens with a high cycle.
- Every preamble and bridge state is followed by data.
- Beat pairs come in order.
- The termination returns only after a high cycle.
- A rejected READ leaves the schedule untouched.
- Both error flags stay set.

Only the bench scenarios can show the following:
- The exact latency from command to data.
- How the window merges at each command spacing.
- That a configuration change is ignored while a burst is running.
- The exact boundary of the read-to-write delay.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_BEAT_A,
        PH_BEAT_B,
        PH_BRIDGE,
        PH_POST
    } phase_t;
endpackage

// File: rtl/rd_cmd_sched.sv
module rd_cmd_sched #(
    parameter int MAX_CL = 16,
    parameter int LAT_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_wr,
    input  logic [LAT_W-1:0] cfg_cl,
    input  logic [LAT_W-1:0] cfg_wl,
    input  logic             phase_idle,
    output logic             start_next,
    output logic             start_in2,
    output logic             rd_accept,
    output logic             wr_req,
    output logic [LAT_W:0]   rtw_now,
    output logic             rd_gap_err
);
    localparam int RTW_W = LAT_W + 1;

    logic [MAX_CL-1:0] due_q, due_n, start_bit;
    logic [LAT_W-1:0]  cl_q, wl_q, cl_eff, wl_eff;
    logic [1:0]        since_col;
    logic              idle_all, rd_req;
    logic [RTW_W-1:0]  cl_sum;

    assign idle_all = phase_idle && (due_q == '0);
    assign cl_eff   = idle_all ? cfg_cl : cl_q;
    assign wl_eff   = idle_all ? cfg_wl : wl_q;
    assign rd_req   = cmd_valid && !cmd_wr;
    assign wr_req   = cmd_valid && cmd_wr;
    assign rd_accept = rd_req && (since_col == 2'd2);

    // start slot k means burst begins k cycles after the next cycle starts
    always_comb begin
        for (int k = 0; k < MAX_CL; k++) begin
            start_bit[k] = rd_accept && (cl_eff == LAT_W'(k + 1));
        end
        due_n = (due_q >> 1) | start_bit;
    end

    always_comb begin
        cl_sum  = {1'b0, cl_eff} + RTW_W'(4);
        rtw_now = (cl_sum > {1'b0, wl_eff}) ? (cl_sum - {1'b0, wl_eff}) : '0;
    end

    assign start_next = due_q[1];
    assign start_in2  = due_q[2];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            due_q      <= '0;
            cl_q       <= LAT_W'(3);
            wl_q       <= '0;
            since_col  <= 2'd2;
            rd_gap_err <= 1'b0;
        end else begin
            due_q <= due_n;
            cl_q  <= cl_eff;
            wl_q  <= wl_eff;
            if (rd_accept || wr_req) begin
                since_col <= 2'd1;
            end else if (since_col != 2'd2) begin
                since_col <= since_col + 2'd1;
            end
            if (rd_req && !rd_accept) begin
                rd_gap_err <= 1'b1;
            end
        end
    end

    AST_RD_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_gap_err |=> rd_gap_err); // R7
    AST_REJECT_NO_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_accept) |=> (due_q == ($past(due_q) >> 1))); // R7
endmodule

// File: rtl/rd_bus_fsm.sv
module rd_bus_fsm
    import rdseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_next,
    input  logic start_in2,
    output logic phase_idle,
    output logic odt_en,
    output logic drv_en,
    output logic drive_high,
    output logic dq_valid,
    output logic dq_pair
);
    phase_t phase_q, phase_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_n;
        end
    end

    always_comb begin
        phase_n = PH_IDLE;
        unique case (phase_q)
            PH_IDLE:   phase_n = start_in2 ? PH_PRE : PH_IDLE;
            PH_PRE:    phase_n = PH_BEAT_A;
            PH_BEAT_A: phase_n = PH_BEAT_B;
            PH_BEAT_B: begin
                if (start_next) begin
                    phase_n = PH_BEAT_A;
                end else if (start_in2) begin
                    phase_n = PH_BRIDGE;
                end else begin
                    phase_n = PH_POST;
                end
            end
            PH_BRIDGE: phase_n = PH_BEAT_A;
            PH_POST:   phase_n = start_in2 ? PH_PRE : PH_IDLE;
            default:   phase_n = PH_IDLE;
        endcase
    end

    always_comb begin
        phase_idle = (phase_q == PH_IDLE);
        odt_en     = (phase_q == PH_IDLE);
        drv_en     = (phase_q != PH_IDLE);
        drive_high = (phase_q == PH_PRE) || (phase_q == PH_BRIDGE) || (phase_q == PH_POST);
        dq_valid   = (phase_q == PH_BEAT_A) || (phase_q == PH_BEAT_B);
        dq_pair    = (phase_q == PH_BEAT_B);
    end

    AST_HIGH_LEADS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_q == PH_PRE) || (phase_q == PH_BRIDGE)) |-> start_next); // R3
    AST_NO_COLD_START: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_q == PH_IDLE) || (phase_q == PH_POST)) |-> !start_next); // R3
    AST_FIRST_DRIVE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_en) |-> (drive_high && !dq_valid)); // R3
    AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_valid && !dq_pair) |=> (dq_valid && dq_pair)); // R2
    AST_ODT_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(odt_en) |-> $past(drive_high)); // R4
endmodule

// File: rtl/rd_wr_gap_chk.sv
module rd_wr_gap_chk #(
    parameter int LAT_W = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rd_accept,
    input  logic           wr_req,
    input  logic [LAT_W:0] rtw_now,
    output logic           wr_gap_err
);
    localparam int CNT_W = LAT_W + 1;

    logic [CNT_W-1:0] since_rd, rtw_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rd   <= '1;
            rtw_q      <= '0;
            wr_gap_err <= 1'b0;
        end else begin
            if (rd_accept) begin
                since_rd <= CNT_W'(1);
                rtw_q    <= rtw_now;
            end else if (since_rd != '1) begin
                since_rd <= since_rd + CNT_W'(1);
            end
            if (wr_req && (since_rd < rtw_q)) begin
                wr_gap_err <= 1'b1;
            end
        end
    end

    AST_WR_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_gap_err |=> wr_gap_err); // R8
    AST_WR_LATE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_gap_err && !(wr_req && (since_rd < rtw_q))) |=> !wr_gap_err); // R8
endmodule

// File: rtl/rd_bus_seq.sv
module rd_bus_seq #(
    parameter int MAX_CL = 16,
    parameter int LAT_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_wr,
    input  logic [LAT_W-1:0] cfg_cl,
    input  logic [LAT_W-1:0] cfg_wl,
    output logic             odt_en,
    output logic             drv_en,
    output logic             drive_high,
    output logic             dq_valid,
    output logic             dq_pair,
    output logic             rd_gap_err,
    output logic             wr_gap_err
);
    logic           start_next, start_in2, phase_idle, rd_accept, wr_req;
    logic [LAT_W:0] rtw_now;

    rd_cmd_sched #(.MAX_CL(MAX_CL), .LAT_W(LAT_W)) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_wr     (cmd_wr),
        .cfg_cl     (cfg_cl),
        .cfg_wl     (cfg_wl),
        .phase_idle (phase_idle),
        .start_next (start_next),
        .start_in2  (start_in2),
        .rd_accept  (rd_accept),
        .wr_req     (wr_req),
        .rtw_now    (rtw_now),
        .rd_gap_err (rd_gap_err)
    );

    rd_bus_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_next (start_next),
        .start_in2  (start_in2),
        .phase_idle (phase_idle),
        .odt_en     (odt_en),
        .drv_en     (drv_en),
        .drive_high (drive_high),
        .dq_valid   (dq_valid),
        .dq_pair    (dq_pair)
    );

    rd_wr_gap_chk #(.LAT_W(LAT_W)) u_gap (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_accept  (rd_accept),
        .wr_req     (wr_req),
        .rtw_now    (rtw_now),
        .wr_gap_err (wr_gap_err)
    );
endmodule

// File: tb/rd_bus_seq_tb.sv
`timescale 1ns/1ps
module rd_bus_seq_tb;
    localparam int LAT_W  = 5;
    localparam int MAX_CL = 16;

    logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0, cmd_wr = 1'b0;
    logic [LAT_W-1:0] cfg_cl = 5'd5, cfg_wl = 5'd2;
    logic odt_en, drv_en, drive_high, dq_valid, dq_pair, rd_gap_err, wr_gap_err;

    rd_bus_seq #(.MAX_CL(MAX_CL), .LAT_W(LAT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_wr(cmd_wr),
        .cfg_cl(cfg_cl), .cfg_wl(cfg_wl), .odt_en(odt_en), .drv_en(drv_en),
        .drive_high(drive_high), .dq_valid(dq_valid), .dq_pair(dq_pair),
        .rd_gap_err(rd_gap_err), .wr_gap_err(wr_gap_err)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct { int c; bit pair; } beat_t;
    beat_t exp_q[$];
    logic [1:0] mark [0:4095];

    int checks = 0, errors = 0;
    bit mon_on = 0, done = 0;
    int last_col = -100, last_rd = -100, last_end = -100;
    int bcl = 5, bwl = 2, brtw = 0;
    bit e_rd = 0, e_wr = 0;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // driver: caller sits at a negedge; the command is sampled at the next posedge
    task automatic issue(bit wr);
        cmd_valid = 1'b1;
        cmd_wr    = wr;
        if (wr) begin
            if (cyc - last_rd < brtw) e_wr = 1;
            last_col = cyc;
        end else if (cyc - last_col < 2) begin
            e_rd = 1;
        end else begin
            if (cyc >= last_end + 2) begin
                bcl = int'(cfg_cl);
                bwl = int'(cfg_wl);
            end
            brtw = (bcl + 4 > bwl) ? bcl + 4 - bwl : 0;
            mark[cyc + bcl]     = 2'd1;
            mark[cyc + bcl + 1] = 2'd2;
            exp_q.push_back('{cyc + bcl, 1'b0});
            exp_q.push_back('{cyc + bcl + 1, 1'b1});
            last_end = cyc + bcl + 1;
            last_col = cyc;
            last_rd  = cyc;
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_wr    = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_to(int c);
        while (cyc < c) @(negedge clk);
    endtask

    // monitor: compares the bus phase each cycle and pops the beat scoreboard
    always @(negedge clk) begin
        if (mon_on) begin
            bit d0, dm, dp, hi, drv;
            d0  = (mark[cyc] != 2'd0);
            dm  = (cyc > 0) ? (mark[cyc - 1] != 2'd0) : 1'b0;
            dp  = (mark[cyc + 1] != 2'd0);
            hi  = !d0 && (dm || dp);
            drv = d0 || hi;
            chk("R3 R4 R5 R6 drive_high", int'(drive_high), int'(hi));
            chk("R3 R4 R5 R6 drv_en", int'(drv_en), int'(drv));
            chk("R3 R4 R5 R6 odt_en", int'(odt_en), int'(!drv));
            if (exp_q.size() > 0 && exp_q[0].c == cyc) begin
                chk("R2 dq_valid", int'(dq_valid), 1);
                chk("R2 dq_pair", int'(dq_pair), int'(exp_q[0].pair));
                void'(exp_q.pop_front());
            end else begin
                chk("R2 R7 dq_valid idle", int'(dq_valid), 0);
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int t;
        for (int i = 0; i < 4096; i++) mark[i] = 2'd0;
        idle(3);
        chk("R1 odt_en reset", int'(odt_en), 1);
        chk("R1 drv_en reset", int'(drv_en), 0);
        chk("R1 drive_high reset", int'(drive_high), 0);
        chk("R1 dq_valid reset", int'(dq_valid), 0);
        rst_n = 1'b1;
        mon_on = 1;
        idle(2);
        chk("R1 rd_gap_err", int'(rd_gap_err), 0);
        chk("R1 wr_gap_err", int'(wr_gap_err), 0);

        // single burst: R2 R3 R4
        issue(0); idle(12);
        // gapless: R5
        issue(0); idle(1); issue(0); idle(1); issue(0); idle(12);
        // spacings 3, 4, 5: R6
        issue(0); idle(2); issue(0); idle(3); issue(0); idle(4); issue(0); idle(12);

        // R9: latency frozen during a burst
        cfg_cl = 5'd3;
        idle(1);
        issue(0);
        cfg_cl = 5'd7;
        idle(1);
        t = cyc;
        issue(0);
        wait_to(t + 3);
        chk("R9 second read keeps running CL", int'(dq_valid), 1);
        idle(12);
        t = cyc;
        issue(0);
        wait_to(t + 7);
        chk("R9 idle read takes new CL", int'(dq_valid), 1);
        idle(12);
        cfg_cl = 5'd5;
        idle(1);

        // R8: CL=5, WL=2 gives delay 7
        issue(0); idle(6); issue(1); idle(2);
        chk("R8 write at exact delay", int'(wr_gap_err), int'(e_wr));
        chk("R8 write at exact delay clean", int'(wr_gap_err), 0);
        idle(12);
        issue(0); idle(5); issue(1); idle(1);
        chk("R8 early write flag", int'(wr_gap_err), 1);
        idle(12);
        chk("R8 flag sticky", int'(wr_gap_err), 1);

        // R7: read right after write, then read right after read
        chk("R7 flag clear before", int'(rd_gap_err), 0);
        issue(1); issue(0); idle(1);
        chk("R7 read after write flag", int'(rd_gap_err), int'(e_rd));
        chk("R7 read after write flag set", int'(rd_gap_err), 1);
        idle(12);
        issue(0); issue(0); idle(12);
        chk("R7 flag sticky", int'(rd_gap_err), 1);
        chk("R7 scoreboard drained", exp_q.size(), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule